// File: doc/BRIEF.md
# Packed Byte Shuffle and Align Unit

This block is a SIMD byte-permutation datapath for a vector execution pipeline. It works on 8-bit elements and supports two operand widths: a full-width mode with 16 lanes (128 bits) and a narrow mode with 8 lanes (64 bits). It performs one of two permutations on each accepted operation.

The table-lookup shuffle builds every result byte from operand A. The matching byte of operand B picks which byte of A to use, and a set top bit in that byte of B forces the result byte to zero.

The window extract joins the two operands into one double-width value and returns one register-width slice of it. The slice starts at a byte offset taken from an immediate. Each operation presented with the valid strobe produces a registered result one cycle later. A new operation can be accepted on every cycle.

Top module: `byte_perm_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid_o` is 0 and `result_o` is all zeros.
- R2: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high. Back-to-back operations each produce a result on consecutive cycles.
- R3: With `op_i` = 0 (shuffle) and `wide_i` = 1, result byte i (bits 8i+7..8i) equals byte k of `opa_i`, where k is bits 3..0 of byte i of `opb_i`. This holds whenever bit 7 of that byte is clear.
- R4: In shuffle mode, result byte i is zero whenever bit 7 of byte i of `opb_i` is set, in either width mode.
- R5: With `wide_i` = 0, only bytes 0..7 of each operand take part and result bytes 8..15 are zero. In shuffle, the index uses only bits 2..0 of the index byte, and bits 6..3 have no effect.
- R6: With `op_i` = 1 (align), result byte j equals byte (imm + j) of the concatenation {A, B}. B is the less significant half. The concatenation has 32 bytes in wide mode and 16 bytes in narrow mode.
- R7: In align mode, a byte position past the end of the concatenation reads as zero. An 8-bit immediate of at least 32 (wide) or 16 (narrow) therefore yields an all-zero result.
- R8: In a cycle with `in_valid_i` low, `result_o` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = shuffle, 1 = align |
| wide_i | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands |
| imm_i | input | IMM_W (8) | Byte offset for align |
| opa_i | input | LANES*8 (128) | Operand A (shuffle source, align upper half) |
| opb_i | input | LANES*8 (128) | Operand B (shuffle indices, align lower half) |
| out_valid_o | output | 1 | Result valid, one cycle after `in_valid_i` |
| result_o | output | LANES*8 (128) | Registered result |

## Verification
The bench builds the unit with its default parameters: 16 lanes and an 8-bit immediate. Driving `wide_i` low then covers the 8-lane geometry in the same build. With these values the whole immediate range, 0 to 255, can be swept in both widths. This covers every in-range window, the exact boundary where bytes start reading past the concatenation, and every fully out-of-range offset. All 256 index byte values are also driven through every shuffle lane in both widths. That covers the zeroing bit and the ignored middle index bits.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  typedef enum logic {
    OP_SHUF  = 1'b0,
    OP_ALIGN = 1'b1
  } bperm_op_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/bperm_shuffle.sv
module bperm_shuffle
  import bperm_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                      wide,
  input  logic [LANES*BYTE_W-1:0]   src,
  input  logic [LANES*BYTE_W-1:0]   idx,
  output logic [LANES*BYTE_W-1:0]   res
);
  localparam int IDX_W  = $clog2(LANES);
  localparam int HALF   = LANES / 2;

  logic [BYTE_W-1:0] src_b [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_unpack
    assign src_b[k] = src[k*BYTE_W +: BYTE_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0]  sel;
    logic              kill;
    always_comb begin
      sel = idx[l*BYTE_W +: IDX_W];
      if (!wide) sel[IDX_W-1] = 1'b0;
      kill = idx[l*BYTE_W + BYTE_W - 1] || (!wide && (l >= HALF));
      res[l*BYTE_W +: BYTE_W] = kill ? '0 : src_b[sel];
    end
  end
endmodule

// File: rtl/bperm_align.sv
module bperm_align
  import bperm_pkg::*;
#(
  parameter int LANES = 16,
  parameter int IMM_W = 8
) (
  input  logic                      wide,
  input  logic [IMM_W-1:0]          imm,
  input  logic [LANES*BYTE_W-1:0]   hi,
  input  logic [LANES*BYTE_W-1:0]   lo,
  output logic [LANES*BYTE_W-1:0]   res
);
  localparam int CAT    = 2 * LANES;
  localparam int HALF   = LANES / 2;
  localparam int CAT_IW = $clog2(CAT);
  localparam int POS_W  = ((IMM_W > CAT_IW) ? IMM_W : CAT_IW) + 1;

  logic [BYTE_W-1:0] cat_b [CAT];

  for (genvar k = 0; k < CAT; k++) begin : g_cat
    always_comb begin
      if (wide) begin
        cat_b[k] = (k < LANES) ? lo[(k % LANES)*BYTE_W +: BYTE_W]
                               : hi[(k % LANES)*BYTE_W +: BYTE_W];
      end else if (k < HALF) begin
        cat_b[k] = lo[(k % LANES)*BYTE_W +: BYTE_W];
      end else if (k < LANES) begin
        cat_b[k] = hi[((k - HALF) % LANES)*BYTE_W +: BYTE_W];
      end else begin
        cat_b[k] = '0;
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] limit;
    always_comb begin
      pos   = POS_W'(imm) + POS_W'(j);
      limit = wide ? POS_W'(CAT) : POS_W'(LANES);
      if ((!wide && (j >= HALF)) || (pos >= limit))
        res[j*BYTE_W +: BYTE_W] = '0;
      else
        res[j*BYTE_W +: BYTE_W] = cat_b[pos[CAT_IW-1:0]];
    end
  end
endmodule

// File: rtl/byte_perm_unit.sv
module byte_perm_unit
  import bperm_pkg::*;
#(
  parameter int LANES = 16,
  parameter int IMM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid_i,
  input  logic                    op_i,
  input  logic                    wide_i,
  input  logic [IMM_W-1:0]        imm_i,
  input  logic [LANES*8-1:0]      opa_i,
  input  logic [LANES*8-1:0]      opb_i,
  output logic                    out_valid_o,
  output logic [LANES*8-1:0]      result_o
);
  localparam int DATA_W = LANES * BYTE_W;

  logic [DATA_W-1:0] shuf_res;
  logic [DATA_W-1:0] algn_res;
  bperm_op_e         op;

  assign op = bperm_op_e'(op_i);

  bperm_shuffle #(.LANES(LANES)) u_shuf (
    .wide (wide_i),
    .src  (opa_i),
    .idx  (opb_i),
    .res  (shuf_res)
  );

  bperm_align #(.LANES(LANES), .IMM_W(IMM_W)) u_algn (
    .wide (wide_i),
    .imm  (imm_i),
    .hi   (opa_i),
    .lo   (opb_i),
    .res  (algn_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i)
        result_o <= (op == OP_ALIGN) ? algn_res : shuf_res;
    end
  end
endmodule

// File: rtl/bperm_checker.sv
module bperm_checker #(
  parameter int LANES = 16,
  parameter int IMM_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid_i,
  input  logic               op_i,
  input  logic               wide_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [LANES*8-1:0] opb_i,
  input  logic               out_valid_o,
  input  logic [LANES*8-1:0] result_o
);
  localparam int DATA_W = LANES * 8;

  logic all_top;
  always_comb begin
    all_top = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (!opb_i[i*8+7]) all_top = 1'b0;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!out_valid_o && (result_o == '0)));

  assert_valid_on_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);

  assert_valid_off_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !out_valid_o);

  assert_shuf_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !op_i && all_top) |=> (result_o == '0));

  assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !wide_i) |=> (result_o[DATA_W-1:DATA_W/2] == '0));

  assert_align_far_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && op_i && (int'(imm_i) >= (wide_i ? 2*LANES : LANES)))
      |=> (result_o == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(result_o));
endmodule

bind byte_perm_unit bperm_checker #(.LANES(LANES), .IMM_W(IMM_W)) u_bperm_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .wide_i      (wide_i),
  .imm_i       (imm_i),
  .opb_i       (opb_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o)
);

// File: tb/test_byte_perm_unit.sv
module test_byte_perm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 16;
  localparam int IMM_W  = 8;
  localparam int DATA_W = LANES * 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid_i = 1'b0;
  logic              op_i = 1'b0;
  logic              wide_i = 1'b1;
  logic [IMM_W-1:0]  imm_i = '0;
  logic [DATA_W-1:0] opa_i = '0;
  logic [DATA_W-1:0] opb_i = '0;
  logic              out_valid_o;
  logic [DATA_W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_perm_unit #(.LANES(LANES), .IMM_W(IMM_W)) i_byte_perm_unit (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .op_i(op_i),
    .wide_i(wide_i), .imm_i(imm_i), .opa_i(opa_i), .opb_i(opb_i),
    .out_valid_o(out_valid_o), .result_o(result_o)
  );

  function automatic logic [DATA_W-1:0] ref_shuf(logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b, bit wide);
    logic [DATA_W-1:0] r = '0;
    int n = wide ? LANES : LANES/2;
    for (int i = 0; i < n; i++) begin
      int k = wide ? (b[i*8 +: 8] % 16) : (b[i*8 +: 8] % 8);
      if (b[i*8+7] == 1'b0) r[i*8 +: 8] = a[k*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] ref_align(logic [DATA_W-1:0] a,
                                                  logic [DATA_W-1:0] b,
                                                  int imm, bit wide);
    logic [2*DATA_W-1:0] cat;
    logic [DATA_W-1:0]   r = '0;
    if (wide) begin
      cat = {a, b};
      cat = cat >> (8 * imm);
      r = cat[DATA_W-1:0];
    end else begin
      cat = '0;
      cat[DATA_W-1:0] = {a[DATA_W/2-1:0], b[DATA_W/2-1:0]};
      cat = cat >> (8 * imm);
      r[DATA_W/2-1:0] = cat[DATA_W/2-1:0];
    end
    return r;
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] got, logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one operation at a negedge, check its result at the next negedge.
  task automatic run_op(string req, bit op, bit wide, int imm,
                        logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                        logic [DATA_W-1:0] exp);
    in_valid_i = 1'b1; op_i = op; wide_i = wide; imm_i = IMM_W'(imm);
    opa_i = a; opb_i = b;
    @(negedge clk);
    check("R2", {{(DATA_W-1){1'b0}}, out_valid_o}, 1);
    check(req, result_o, exp);
  endtask

  function automatic logic [DATA_W-1:0] pat_a(int s);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*8 +: 8] = 8'((k * 29) + (s * 3) + 1);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] a, b, last;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1", {{(DATA_W-1){1'b0}}, out_valid_o}, 0);
    check("R1", result_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {{(DATA_W-1){1'b0}}, out_valid_o}, 0);
    check("R1", result_o, '0);

    // R3/R4: wide shuffle, all index byte values through every lane
    for (int v = 0; v < 256; v++) begin
      a = pat_a(v);
      for (int i = 0; i < LANES; i++) b[i*8 +: 8] = 8'(v + i * 7);
      run_op(v >= 128 ? "R4" : "R3", 1'b0, 1'b1, 0, a, b, ref_shuf(a, b, 1'b1));
    end
    // R4: every top bit set
    a = pat_a(5);
    b = {LANES{8'h83}};
    run_op("R4", 1'b0, 1'b1, 0, a, b, '0);
    // R5: narrow shuffle, bits 6..3 ignored, upper bytes zero
    for (int v = 0; v < 256; v++) begin
      a = pat_a(v + 11);
      for (int i = 0; i < LANES; i++) b[i*8 +: 8] = 8'(v + i * 13);
      run_op("R5", 1'b0, 1'b0, 0, a, b, ref_shuf(a, b, 1'b0));
    end
    a = pat_a(9);
    b = {LANES{8'h7A}};
    run_op("R5", 1'b0, 1'b0, 0, a, b, {{(DATA_W/2){1'b0}}, {(LANES/2){a[2*8 +: 8]}}});

    // R6/R7: align, full immediate range, both widths
    for (int w = 0; w < 2; w++) begin
      for (int imm = 0; imm < 256; imm++) begin
        a = pat_a(imm);
        b = ~pat_a(imm + 77);
        run_op((imm >= (w == 1 ? 32 : 16)) ? "R7" : "R6", 1'b1, w[0], imm, a, b,
               ref_align(a, b, imm, w[0]));
      end
    end
    // R6: offset 0 returns B, offset = width returns A
    a = pat_a(40); b = pat_a(41);
    run_op("R6", 1'b1, 1'b1, 0, a, b, b);
    run_op("R6", 1'b1, 1'b1, 16, a, b, a);

    // R8: idle cycles with changing inputs leave result unchanged
    last = result_o;
    for (int t = 0; t < 4; t++) begin
      in_valid_i = 1'b0; op_i = t[0]; wide_i = t[1];
      imm_i = IMM_W'(t * 5); opa_i = pat_a(t + 100); opb_i = ~pat_a(t);
      @(negedge clk);
      check("R2", {{(DATA_W-1){1'b0}}, out_valid_o}, 0);
      check("R8", result_o, last);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule